// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns a DMA request expressed in logical addresses into a series of physical memory bursts. A flat translation table lives in system memory. Each 8-byte slot of that table holds a 32-bit physical frame address in its first word, and a 32-bit owner word follows it that this block never reads. A request gives a logical start address, a byte count and a direction. The block cuts the request into pieces that never straddle a 4096-byte page. For each piece it reads the frame word of the matching table slot over a single-word read port, then issues one physical burst over a separate transfer port.

Two 32-bit configuration registers set the table origin (`base`) and the table size in bytes (`limit`). A logical page whose number reaches `limit / 8` has no slot. When the walk meets such a page it stops at once, skips every remaining piece and reports the early end through a status bit. Both registers reset to zero, so a transfer started before setup ends immediately with that status.

The control is a five-state machine:
- `ST_IDLE`: waits for a request.
- `ST_EVAL`: decides whether the walk is finished, must stop on the limit, or needs a table read.
- `ST_FETCH`: holds the table read.
- `ST_MOVE`: holds the data burst.
- `ST_DONE`: pulses completion.

The transitions are:
- accept: `ST_IDLE` to `ST_EVAL`, on a valid request.
- finish: `ST_EVAL` to `ST_DONE`, when no bytes remain.
- stop: `ST_EVAL` to `ST_DONE`, when the page number fails the limit check.
- lookup: `ST_EVAL` to `ST_FETCH`, otherwise.
- translate: `ST_FETCH` to `ST_MOVE`, on the table read acknowledge.
- advance: `ST_MOVE` to `ST_EVAL`, on the burst acknowledge.
- report: `ST_DONE` to `ST_IDLE`, unconditionally.

Top module: `pgw_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `done`, `ent_req` and `xfer_req` are 0, and `base` and `limit` are zero. A transfer of nonzero length made before any setup therefore ends with `aborted`=1 and no table read.
- R2: Each burst length equals the smaller of (4096 minus the logical address bits [11:0]) and the bytes still left, so no burst crosses a 4096-byte logical page.
- R3: The table read address equals (`base` + (logical address >> 12) * 8), with bit 31 forced to 0.
- R4: When (logical address >> 12) is greater than or equal to (`limit` >> 3), the walk stops. No further table read or burst is issued, and `aborted` reads 1 while `done` is high.
- R5: The burst address equals the returned frame word plus the logical address bits [11:0], and `xfer_write` equals the `req_write` captured with the request (1 means a write to memory).
- R6: At most one table read is outstanding. `ent_req` and `xfer_req` are never high together, and a burst for a piece begins only after that piece's table read has been acknowledged.
- R7: After each burst, the logical address advances by the burst length and the bytes left drop by the same amount. When every byte has moved, `done` is high for exactly one cycle with `aborted`=0.
- R8: A request of length zero completes with `done` and `aborted`=0, with no table read or burst.
- R9: `req_ready` is 1 only while idle. A raised `ent_req` or `xfer_req` stays high with a stable address and length until its acknowledge is seen.
- R10: A configuration write with `cfg_we`=1 loads `cfg_wdata` into `base` when `cfg_sel`=0 and into `limit` when `cfg_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 32 | Logical start address |
| req_len | input | 16 | Byte count |
| req_write | input | 1 | 1 = device to memory, 0 = memory to device |
| ent_req | output | 1 | Table read request |
| ent_addr | output | 32 | Table read address |
| ent_ack | input | 1 | Table read acknowledge with data |
| ent_data | input | 32 | Frame word returned by the table read |
| xfer_req | output | 1 | Physical burst request |
| xfer_addr | output | 32 | Physical burst address |
| xfer_len | output | 13 | Burst length in bytes (1 to 4096) |
| xfer_write | output | 1 | Burst direction |
| xfer_ack | input | 1 | Burst complete |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Walk stopped by the limit check |

## Verification
A request seen at a clock edge in `ST_IDLE` takes the block to `ST_EVAL` at that edge. `ent_req` rises one edge later, and a zero-length or limit-stopped walk raises `done` at that same later edge instead. Each acknowledge moves the machine on at the edge where it is sampled, so `xfer_req` follows a table acknowledge by one edge, and the next `ST_EVAL` decision follows a burst acknowledge by one edge. The bench's responders raise the acknowledges at a falling edge after they see a request there, and they log the request's fields at that moment. The bench samples `done`, `aborted` and `req_ready` only at falling edges, polls for `done`, and then checks that `done` has dropped at the very next falling edge.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVAL  = 3'd1,
        ST_FETCH = 3'd2,
        ST_MOVE  = 3'd3,
        ST_DONE  = 3'd4
    } walk_state_t;

endpackage

// File: rtl/pgw_cfg.sv
module pgw_cfg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] tbl_base,
    output logic [ADDR_W-1:0] tbl_limit
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base  <= '0;
            tbl_limit <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) tbl_limit <= cfg_wdata;
            else         tbl_base  <= cfg_wdata;
        end
    end

endmodule

// File: rtl/pgw_chunk.sv
module pgw_chunk #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12,
    parameter int ENT_LOG2  = 3,
    localparam int CHUNK_W  = PAGE_BITS + 1
) (
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [LEN_W-1:0]   remain,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic [ADDR_W-1:0]  tbl_limit,
    output logic [CHUNK_W-1:0] chunk_len,
    output logic [ADDR_W-1:0]  slot_addr,
    output logic               over_limit,
    output logic               empty
);

    localparam int IDX_W     = ADDR_W - PAGE_BITS;
    localparam int CMP_W     = (LEN_W > CHUNK_W) ? LEN_W : CHUNK_W;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;
    localparam logic [ADDR_W-1:0] SLOT_MASK = {1'b0, {(ADDR_W-1){1'b1}}};

    logic [IDX_W-1:0]   page_idx;
    logic [CHUNK_W-1:0] page_left;
    logic [CMP_W-1:0]   left_x;
    logic [CMP_W-1:0]   rem_x;
    logic [ADDR_W-1:0]  slot_sum;

    always_comb begin
        page_idx   = cur_addr[ADDR_W-1:PAGE_BITS];
        page_left  = CHUNK_W'(PAGE_SIZE) - CHUNK_W'(cur_addr[PAGE_BITS-1:0]);
        left_x     = CMP_W'(page_left);
        rem_x      = CMP_W'(remain);
        chunk_len  = (rem_x < left_x) ? CHUNK_W'(remain) : page_left;
        slot_sum   = tbl_base + (ADDR_W'(page_idx) << ENT_LOG2);
        slot_addr  = slot_sum & SLOT_MASK;
        over_limit = ADDR_W'(page_idx) >= (tbl_limit >> ENT_LOG2);
        empty      = (remain == '0);
    end

endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12,
    localparam int CHUNK_W  = PAGE_BITS + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_write,
    input  logic [CHUNK_W-1:0] chunk_len,
    input  logic [ADDR_W-1:0]  slot_addr,
    input  logic               over_limit,
    input  logic               empty,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [LEN_W-1:0]   remain,
    output logic               ent_req,
    output logic [ADDR_W-1:0]  ent_addr,
    input  logic               ent_ack,
    input  logic [ADDR_W-1:0]  ent_data,
    output logic               xfer_req,
    output logic [ADDR_W-1:0]  xfer_addr,
    output logic [CHUNK_W-1:0] xfer_len,
    output logic               xfer_write,
    input  logic               xfer_ack,
    output logic               done,
    output logic               aborted
);

    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    walk_state_t state_q, state_d;

    logic [ADDR_W-1:0]  slot_q;
    logic [ADDR_W-1:0]  phys_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic               dir_q;
    logic               abort_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_EVAL;
            ST_EVAL: begin
                if (empty || over_limit) state_d = ST_DONE;
                else                     state_d = ST_FETCH;
            end
            ST_FETCH: if (ent_ack)  state_d = ST_MOVE;
            ST_MOVE:  if (xfer_ack) state_d = ST_EVAL;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            slot_q   <= '0;
            phys_q   <= '0;
            chunk_q  <= '0;
            dir_q    <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    cur_addr <= req_addr;
                    remain   <= req_len;
                    dir_q    <= req_write;
                    abort_q  <= 1'b0;
                end
                ST_EVAL: begin
                    slot_q  <= slot_addr;
                    chunk_q <= chunk_len;
                    if (!empty && over_limit) abort_q <= 1'b1;
                end
                ST_FETCH: if (ent_ack) begin
                    phys_q <= ent_data + ADDR_W'(cur_addr[PAGE_BITS-1:0]);
                end
                ST_MOVE: if (xfer_ack) begin
                    cur_addr <= cur_addr + ADDR_W'(chunk_q);
                    remain   <= remain - LEN_W'(chunk_q);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        ent_req    = (state_q == ST_FETCH);
        ent_addr   = slot_q;
        xfer_req   = (state_q == ST_MOVE);
        xfer_addr  = phys_q;
        xfer_len   = chunk_q;
        xfer_write = dir_q;
        done       = (state_q == ST_DONE);
        aborted    = abort_q;
    end

    // R6: table read and data burst never overlap
    a_r6_one_port_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(ent_req && xfer_req));

    // R6: a burst begins only right after an acknowledged table read
    a_r6_burst_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> $past(ent_req && ent_ack));

    // R9: held table read keeps its address
    a_r9_ent_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_req && !ent_ack) |=> (ent_req && $stable(ent_addr)));

    // R9: held burst keeps address, length and direction
    a_r9_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=>
            (xfer_req && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_write)));

    // R2: burst stays inside the current logical page and is non-empty
    a_r2_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> ((xfer_len != '0) &&
            ((CHUNK_W+1)'(cur_addr[PAGE_BITS-1:0]) + (CHUNK_W+1)'(xfer_len)
                <= (CHUNK_W+1)'(PAGE_SIZE))));

    // R2: burst never exceeds the bytes left
    a_r2_within_remain: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (32'(xfer_len) <= 32'(remain)));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: table read address has bit 31 clear
    a_r3_slot_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req |-> !ent_addr[ADDR_W-1]);

    // R9: no acceptance while a walk is in progress
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ent_req && !xfer_req && !done));

endmodule

// File: rtl/pgw_xlate.sv
module pgw_xlate #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12,
    parameter int ENT_LOG2  = 3,
    localparam int CHUNK_W  = PAGE_BITS + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_write,
    output logic               ent_req,
    output logic [ADDR_W-1:0]  ent_addr,
    input  logic               ent_ack,
    input  logic [ADDR_W-1:0]  ent_data,
    output logic               xfer_req,
    output logic [ADDR_W-1:0]  xfer_addr,
    output logic [CHUNK_W-1:0] xfer_len,
    output logic               xfer_write,
    input  logic               xfer_ack,
    output logic               done,
    output logic               aborted
);

    logic [ADDR_W-1:0]  tbl_base;
    logic [ADDR_W-1:0]  tbl_limit;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remain;
    logic [CHUNK_W-1:0] chunk_len;
    logic [ADDR_W-1:0]  slot_addr;
    logic               over_limit;
    logic               empty;

    pgw_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit)
    );

    pgw_chunk #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .PAGE_BITS (PAGE_BITS),
        .ENT_LOG2  (ENT_LOG2)
    ) u_chunk (
        .cur_addr   (cur_addr),
        .remain     (remain),
        .tbl_base   (tbl_base),
        .tbl_limit  (tbl_limit),
        .chunk_len  (chunk_len),
        .slot_addr  (slot_addr),
        .over_limit (over_limit),
        .empty      (empty)
    );

    pgw_walk_fsm #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_write  (req_write),
        .chunk_len  (chunk_len),
        .slot_addr  (slot_addr),
        .over_limit (over_limit),
        .empty      (empty),
        .cur_addr   (cur_addr),
        .remain     (remain),
        .ent_req    (ent_req),
        .ent_addr   (ent_addr),
        .ent_ack    (ent_ack),
        .ent_data   (ent_data),
        .xfer_req   (xfer_req),
        .xfer_addr  (xfer_addr),
        .xfer_len   (xfer_len),
        .xfer_write (xfer_write),
        .xfer_ack   (xfer_ack),
        .done       (done),
        .aborted    (aborted)
    );

endmodule

// File: tb/pgw_xlate_bench.sv
module pgw_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_write = 1'b0;
    logic        ent_req;
    logic [31:0] ent_addr;
    logic        ent_ack = 1'b0;
    logic [31:0] ent_data = '0;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic [12:0] xfer_len;
    logic        xfer_write;
    logic        xfer_ack = 1'b0;
    logic        done;
    logic        aborted;

    int checks = 0;
    int errors = 0;

    logic [31:0] base_m = '0;
    logic [31:0] limit_m = '0;

    logic [31:0] ent_log  [0:31];
    logic [31:0] xa_log   [0:31];
    logic [12:0] xl_log   [0:31];
    logic        xw_log   [0:31];
    int          ent_n = 0;
    int          xfer_n = 0;

    always #2 clk = ~clk;

    pgw_xlate u_pgw_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write),
        .ent_req(ent_req), .ent_addr(ent_addr), .ent_ack(ent_ack), .ent_data(ent_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_write(xfer_write), .xfer_ack(xfer_ack),
        .done(done), .aborted(aborted)
    );

    function automatic logic [31:0] frame_of(input logic [31:0] ea);
        return 32'h0300_0000 ^ (ea << 8);
    endfunction

    // table-read responder
    initial begin
        forever begin
            @(negedge clk);
            if (ent_req && !ent_ack) begin
                if (ent_n < 32) ent_log[ent_n] = ent_addr;
                ent_n++;
                ent_data = frame_of(ent_addr);
                ent_ack  = 1'b1;
            end else begin
                ent_ack = 1'b0;
            end
        end
    end

    // burst responder
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_req && !xfer_ack) begin
                if (xfer_n < 32) begin
                    xa_log[xfer_n] = xfer_addr;
                    xl_log[xfer_n] = xfer_len;
                    xw_log[xfer_n] = xfer_write;
                end
                xfer_n++;
                xfer_ack = 1'b1;
            end else begin
                xfer_ack = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) limit_m = val; else base_m = val;
    endtask

    // Launches one request, models the expected walk, compares everything.
    task automatic run_walk(input string req, input logic [31:0] addr,
                            input logic [15:0] len, input logic wr);
        logic [31:0] exp_ent [0:31];
        logic [31:0] exp_pa  [0:31];
        logic [12:0] exp_len [0:31];
        int          n = 0;
        logic        exp_ab = 1'b0;
        logic [31:0] a = addr;
        int          rem = len;
        int          wait_cyc = 0;
        logic        got_ab;
        while (rem > 0) begin
            logic [31:0] idx = a >> 12;
            int c = 4096 - int'(a[11:0]);
            if (idx >= (limit_m >> 3)) begin exp_ab = 1'b1; break; end
            if (c > rem) c = rem;
            exp_ent[n] = (base_m + idx * 8) & 32'h7FFF_FFFF;
            exp_pa[n]  = frame_of(exp_ent[n]) + {20'd0, a[11:0]};
            exp_len[n] = 13'(c);
            n++;
            a   = a + 32'(c);
            rem = rem - c;
        end
        ent_n = 0; xfer_n = 0;
        @(negedge clk);
        chk({req, " R9 ready before request"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = addr; req_len = len; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " R9 ready low while busy"}, 32'(req_ready), 32'd0);
        while (!done && wait_cyc < 2000) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk({req, " R7 done seen"}, 32'(done), 32'd1);
        got_ab = aborted;
        chk({req, " R4 aborted status"}, 32'(got_ab), 32'(exp_ab));
        chk({req, " R3 table read count"}, 32'(ent_n), 32'(n));
        chk({req, " R6 burst count"}, 32'(xfer_n), 32'(n));
        for (int i = 0; i < n && i < ent_n && i < xfer_n; i++) begin
            chk({req, " R3 table address"}, ent_log[i], exp_ent[i]);
            chk({req, " R5 physical address"}, xa_log[i], exp_pa[i]);
            chk({req, " R2 burst length"}, 32'(xl_log[i]), 32'(exp_len[i]));
            chk({req, " R5 direction"}, 32'(xw_log[i]), 32'(wr));
        end
        @(negedge clk);
        chk({req, " R7 done one cycle"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 done low", 32'(done), 32'd0);
        chk("R1 ent_req low", 32'(ent_req), 32'd0);
        chk("R1 xfer_req low", 32'(xfer_req), 32'd0);
    endtask

    task automatic t_unconfigured;
        run_walk("R1 unconfigured", 32'h0000_0000, 16'h0040, 1'b0);
    endtask

    task automatic t_single_piece;
        cfg_write(1'b0, 32'h8000_1000);   // R10 base with bit 31 set (R3 mask)
        cfg_write(1'b1, 32'd128);         // R10 limit: 16 slots
        run_walk("R5 single piece", 32'h0000_2010, 16'h0100, 1'b0);
    endtask

    task automatic t_cross_pages;
        run_walk("R2 three pages", 32'h0000_3F00, 16'h1200, 1'b1);
    endtask

    task automatic t_full_page;
        run_walk("R2 aligned full page", 32'h0000_5000, 16'h1000, 1'b0);
    endtask

    task automatic t_limit_stop;
        run_walk("R4 stop at slot 16", 32'h0000_E800, 16'h2000, 1'b1);
    endtask

    task automatic t_zero_len;
        run_walk("R8 zero length", 32'h0000_1234, 16'h0000, 1'b1);
    endtask

    task automatic t_odd_limit;
        cfg_write(1'b0, 32'h0002_0000);
        cfg_write(1'b1, 32'h0000_0017);   // R10: 23 bytes -> 2 slots
        run_walk("R4 odd limit", 32'h0000_1000, 16'h3000, 1'b0);
        run_walk("R7 within odd limit", 32'h0000_0800, 16'h0900, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unconfigured();
        t_single_piece();
        t_cross_pages();
        t_full_page();
        t_limit_stop();
        t_zero_len();
        t_odd_limit();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule